// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests for a small 8-bit processor core and turns them into a single vectored acknowledge. There are three sources. The first is a USB event source, which merges four bus conditions into one flag: FIFO access, suspend, resume and bus reset. The other two are the overflow events of two timers. Each source has a request flag and an enable bit. A global enable gates all of them. All of these bits live in one 8-bit register that software can write and read.

The core supplies an instruction-cycle strobe, a return-stack-full indication and two return strobes: return-from-interrupt and plain return. Requests are judged only on strobe cycles. When one is taken, the controller emits a one-cycle take pulse with the vector address. In the same step it clears the serviced flag and the global enable, so nested servicing is blocked until software re-arms it. A wake-up request follows any pending flag, whatever the enables say. All pins are plain control and status signals, so there is no valid/ready handshake at the edge.

Top module: `icu_vectored`

## Requirements
- R1: Control register layout: bit 0 global enable, bit 1 USB enable, bit 2 timer 0 enable, bit 3 timer 1 enable, bit 4 USB flag, bit 5 timer 0 flag, bit 6 timer 1 flag; bit 7 always reads 0. A register write loads every field in the next cycle, so writing 1 to a flag raises a software request and writing 0 clears it.
- R2: The vector is 0x04 for USB, 0x08 for timer 0 and 0x0C for timer 1.
- R3: When several sources are enabled and pending at once, USB wins over timer 0, and timer 0 wins over timer 1.
- R4: A take needs all four of these in a strobe cycle: the global enable is set, the source enable is set, the source flag is set, and the stack is not full. The take pulse is high for exactly the one cycle after that strobe cycle, with the vector valid in the same cycle.
- R5: Requests are evaluated only in strobe cycles. A request raised between strobes stays pending and is taken on the next strobe.
- R6: A take clears the serviced source's flag and the global enable. The other flags and all source enables keep their values.
- R7: A return-from-interrupt strobe sets the global enable and overrides a register write in the same cycle. A plain return strobe leaves the global enable unchanged. A take in the same cycle as a return-from-interrupt leaves the global enable cleared.
- R8: Any one of the four USB conditions sets the USB flag (bit 4). A timer overflow sets bit 5 or bit 6. The flag reads back set in the cycle after the event.
- R9: A hardware set of a flag wins over a take's clear of that flag, and over a register write of 0, when they fall in the same cycle.
- R10: The wake-up request is high while any flag is set, whatever the enable bits hold.
- R11: After reset the register reads 0, and the take pulse and wake-up request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_strobe | input | 1 | Instruction-cycle strobe; requests are judged when high |
| stack_full | input | 1 | Return stack of the core is full |
| reti_pulse | input | 1 | Return-from-interrupt strobe |
| ret_pulse | input | 1 | Plain return strobe |
| reg_wr_en | input | 1 | Control register write enable |
| reg_wr_data | input | 8 | Control register write value |
| reg_rd_data | output | 8 | Control register read value |
| usb_fifo_evt | input | 1 | USB FIFO access event |
| usb_susp_evt | input | 1 | USB suspend event |
| usb_resume_evt | input | 1 | USB resume event |
| usb_reset_evt | input | 1 | USB bus reset event |
| tmr0_ovf | input | 1 | Timer 0 overflow |
| tmr1_ovf | input | 1 | Timer 1 overflow |
| take_pulse | output | 1 | One-cycle interrupt take |
| vector_addr | output | 8 | Service vector, valid with take_pulse |
| wake_req | output | 1 | Wake-up request |

## Verification
Two things can land on the same flag in one cycle: a take clears it, and a new hardware event sets it again. The bench provokes this by loading a pending, enabled USB flag and then pulsing a USB bus reset event in the same cycle as the strobe that takes it. It judges the outcome by requiring a take with vector 0x04 and the USB flag still reading 1 afterwards. Return-from-interrupt meeting a take, and a hardware event meeting a register write of 0, are provoked the same way. A sweep over every setting of the enables, the flags and stack-full checks priority and gating against values the bench computes itself.

// File: rtl/icu_pkg.sv
package icu_pkg;
  // Index of the USB source; it has the highest priority
  localparam int USB_IDX = 0;

  function automatic int vec_of(input int idx, input int base, input int step);
    return base + idx * step;
  endfunction
endpackage

// File: rtl/icu_req_latch.sv
module icu_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic wr_en,
  input  logic wr_val,
  input  logic ack_clr,
  output logic flag
);
  // A hardware set has precedence, so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (hw_set)  flag <= 1'b1;
    else if (wr_en)   flag <= wr_val;
    else if (ack_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/icu_prio_sel.sv
module icu_prio_sel #(
  parameter int N_SRC    = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic [N_SRC-1:0] req,
  output logic             any,
  output logic [N_SRC-1:0] grant,
  output logic [VEC_W-1:0] vec
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [IDX_W-1:0] idx;

  // Scan from the top so that the lowest index is the one that wins
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end

  assign any = |req;
  assign vec = VEC_W'(icu_pkg::vec_of(int'(idx), VEC_BASE, VEC_STEP));
endmodule

// File: rtl/icu_ctrl.sv
module icu_ctrl #(
  parameter int N_SRC = 3,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_strobe,
  input  logic             stack_full,
  input  logic             reti_pulse,
  input  logic             ret_pulse,
  input  logic             wr_en,
  input  logic             wr_gie,
  input  logic [N_SRC-1:0] wr_src_en,
  input  logic             any_pend,
  input  logic [N_SRC-1:0] grant,
  input  logic [VEC_W-1:0] vec_in,
  output logic             gie,
  output logic [N_SRC-1:0] src_en,
  output logic [N_SRC-1:0] ack_clr,
  output logic             take_pulse,
  output logic [VEC_W-1:0] vector_addr
);
  logic take_now;
  logic gie_ret;
  logic gie_d;

  assign take_now = cyc_strobe & gie & any_pend & ~stack_full;
  assign ack_clr  = take_now ? grant : '0;

  // Precedence for the global enable: take clears, then RETI sets, then a write
  always_comb begin
    case ({reti_pulse, ret_pulse})
      2'b10, 2'b11: gie_ret = 1'b1;
      2'b01:        gie_ret = wr_en ? wr_gie : gie;
      default:      gie_ret = wr_en ? wr_gie : gie;
    endcase
    gie_d = take_now ? 1'b0 : gie_ret;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie         <= 1'b0;
      src_en      <= '0;
      take_pulse  <= 1'b0;
      vector_addr <= '0;
    end else begin
      gie        <= gie_d;
      take_pulse <= take_now;
      if (wr_en)    src_en      <= wr_src_en;
      if (take_now) vector_addr <= vec_in;
    end
  end
endmodule

// File: rtl/icu_vectored.sv
module icu_vectored #(
  parameter int N_SRC    = 3,
  parameter int REG_W    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_strobe,
  input  logic             stack_full,
  input  logic             reti_pulse,
  input  logic             ret_pulse,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             usb_fifo_evt,
  input  logic             usb_susp_evt,
  input  logic             usb_resume_evt,
  input  logic             usb_reset_evt,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  output logic             take_pulse,
  output logic [VEC_W-1:0] vector_addr,
  output logic             wake_req
);
  localparam int EN_LSB = 1;
  localparam int FL_LSB = EN_LSB + N_SRC;
  localparam int PAD_W  = REG_W - FL_LSB - N_SRC;

  logic [N_SRC-1:0] hw_set;
  logic [N_SRC-1:0] flags;
  logic [N_SRC-1:0] src_en;
  logic [N_SRC-1:0] ack_clr;
  logic [N_SRC-1:0] grant;
  logic [VEC_W-1:0] sel_vec;
  logic             any_pend;
  logic             gie;
  logic [3:0]       usb_evt;

  // The USB conditions merge into one source; the timers map one to one
  assign usb_evt = {usb_fifo_evt, usb_susp_evt, usb_resume_evt, usb_reset_evt};

  always_comb begin
    hw_set = '0;
    hw_set[icu_pkg::USB_IDX] = |usb_evt;
    if (N_SRC > 1) hw_set[1] = tmr0_ovf;
    if (N_SRC > 2) hw_set[2] = tmr1_ovf;
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    icu_req_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (hw_set[s]),
      .wr_en   (reg_wr_en),
      .wr_val  (reg_wr_data[FL_LSB + s]),
      .ack_clr (ack_clr[s]),
      .flag    (flags[s])
    );
  end

  icu_prio_sel #(
    .N_SRC    (N_SRC),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_sel (
    .req   (flags & src_en),
    .any   (any_pend),
    .grant (grant),
    .vec   (sel_vec)
  );

  icu_ctrl #(
    .N_SRC (N_SRC),
    .VEC_W (VEC_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_strobe  (cyc_strobe),
    .stack_full  (stack_full),
    .reti_pulse  (reti_pulse),
    .ret_pulse   (ret_pulse),
    .wr_en       (reg_wr_en),
    .wr_gie      (reg_wr_data[0]),
    .wr_src_en   (reg_wr_data[EN_LSB +: N_SRC]),
    .any_pend    (any_pend),
    .grant       (grant),
    .vec_in      (sel_vec),
    .gie         (gie),
    .src_en      (src_en),
    .ack_clr     (ack_clr),
    .take_pulse  (take_pulse),
    .vector_addr (vector_addr)
  );

  assign reg_rd_data = {{PAD_W{1'b0}}, flags, src_en, gie};
  assign wake_req    = |flags;
endmodule

// File: rtl/icu_vectored_chk.sv
module icu_vectored_chk #(
  parameter int N_SRC    = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_strobe,
  input logic             stack_full,
  input logic             reti_pulse,
  input logic             usb_fifo_evt,
  input logic             usb_susp_evt,
  input logic             usb_resume_evt,
  input logic             usb_reset_evt,
  input logic             take_pulse,
  input logic [VEC_W-1:0] vector_addr,
  input logic             wake_req,
  input logic             gie
);
  logic vec_ok;
  always_comb begin
    vec_ok = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (int'(vector_addr) == VEC_BASE + i * VEC_STEP) vec_ok = 1'b1;
  end

  a_r4_take_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |-> ($past(cyc_strobe) && !$past(stack_full)));

  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |=> !take_pulse);

  a_r6_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |-> !gie);

  a_r2_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |-> vec_ok);

  a_r7_reti_arms: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reti_pulse) && !take_pulse) |-> gie);

  a_r10_usb_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_fifo_evt || usb_susp_evt || usb_resume_evt || usb_reset_evt) |=> wake_req);
endmodule

bind icu_vectored icu_vectored_chk #(
  .N_SRC    (N_SRC),
  .VEC_W    (VEC_W),
  .VEC_BASE (VEC_BASE),
  .VEC_STEP (VEC_STEP)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cyc_strobe     (cyc_strobe),
  .stack_full     (stack_full),
  .reti_pulse     (reti_pulse),
  .usb_fifo_evt   (usb_fifo_evt),
  .usb_susp_evt   (usb_susp_evt),
  .usb_resume_evt (usb_resume_evt),
  .usb_reset_evt  (usb_reset_evt),
  .take_pulse     (take_pulse),
  .vector_addr    (vector_addr),
  .wake_req       (wake_req),
  .gie            (gie)
);

// File: tb/icu_vectored_bench.sv
`timescale 1ns/1ps
module icu_vectored_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_strobe = 1'b0, stack_full = 1'b0, reti_pulse = 1'b0, ret_pulse = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic [7:0] reg_rd_data;
  logic       usb_fifo_evt = 1'b0, usb_susp_evt = 1'b0, usb_resume_evt = 1'b0, usb_reset_evt = 1'b0;
  logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0;
  logic       take_pulse, wake_req;
  logic [7:0] vector_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  icu_vectored u_icu_vectored (
    .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .stack_full(stack_full),
    .reti_pulse(reti_pulse), .ret_pulse(ret_pulse), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .usb_fifo_evt(usb_fifo_evt), .usb_susp_evt(usb_susp_evt),
    .usb_resume_evt(usb_resume_evt), .usb_reset_evt(usb_reset_evt),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .take_pulse(take_pulse),
    .vector_addr(vector_addr), .wake_req(wake_req)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = v;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  // Strobe for one cycle; returns at the negedge where take_pulse is visible
  task automatic strobe(input logic sf);
    @(negedge clk); cyc_strobe = 1'b1; stack_full = sf;
    @(negedge clk); cyc_strobe = 1'b0; stack_full = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reg", reg_rd_data, 0);
    chk("R11 take", take_pulse, 0);
    chk("R11 wake", wake_req, 0);

    wr(8'hFF);
    chk("R1 bit7 reads 0", reg_rd_data, 8'h7F);

    // Sweep: global enable, source enables, flags, stack full
    for (int g = 0; g < 2; g++)
      for (int en = 0; en < 8; en++)
        for (int fl = 0; fl < 8; fl++)
          for (int sf = 0; sf < 2; sf++) begin
            automatic logic [7:0] v = 8'((fl << 4) | (en << 1) | g);
            automatic int pend = en & fl;
            automatic int win = (pend & 1) ? 0 : ((pend & 2) ? 1 : 2);
            automatic int tk = (g == 1 && pend != 0 && sf == 0) ? 1 : 0;
            automatic int fl_after = tk ? (fl & ~(1 << win)) : fl;
            wr(v);
            chk("R1 readback", reg_rd_data, v);
            chk("R10 wake", wake_req, fl != 0);
            strobe(sf[0]);
            chk("R4 take", take_pulse, tk);
            if (tk) chk("R2 R3 vector", vector_addr, 4 + 4 * win);
            @(negedge clk);
            chk("R4 single pulse", take_pulse, 0);
            chk("R6 reg after", reg_rd_data,
                (fl_after << 4) | (en << 1) | (tk ? 0 : g));
          end

    // R8: each event sets its flag
    for (int k = 0; k < 6; k++) begin
      wr(8'h00);
      @(negedge clk);
      case (k)
        0: usb_fifo_evt = 1'b1;
        1: usb_susp_evt = 1'b1;
        2: usb_resume_evt = 1'b1;
        3: usb_reset_evt = 1'b1;
        4: tmr0_ovf = 1'b1;
        default: tmr1_ovf = 1'b1;
      endcase
      @(negedge clk);
      {usb_fifo_evt, usb_susp_evt, usb_resume_evt, usb_reset_evt, tmr0_ovf, tmr1_ovf} = '0;
      chk("R8 flag set", reg_rd_data, (k < 4) ? 8'h10 : ((k == 4) ? 8'h20 : 8'h40));
      chk("R10 wake enables off", wake_req, 1);
    end

    // R5: event between strobes waits for the next strobe
    wr(8'h03);
    @(negedge clk); tmr0_ovf = 1'b0; usb_fifo_evt = 1'b1;
    @(negedge clk); usb_fifo_evt = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk("R5 no take without strobe", take_pulse, 0);
      @(negedge clk);
    end
    strobe(1'b0);
    chk("R5 take on strobe", take_pulse, 1);
    chk("R5 vector", vector_addr, 8'h04);
    @(negedge clk);

    // R7: RET keeps, RETI arms
    chk("R7 gie cleared", reg_rd_data[0], 0);
    @(negedge clk); ret_pulse = 1'b1;
    @(negedge clk); ret_pulse = 1'b0;
    chk("R7 RET no effect", reg_rd_data[0], 0);
    @(negedge clk); reti_pulse = 1'b1;
    @(negedge clk); reti_pulse = 1'b0;
    chk("R7 RETI arms", reg_rd_data[0], 1);
    @(negedge clk); reti_pulse = 1'b1; reg_wr_en = 1'b1; reg_wr_data = 8'h00;
    @(negedge clk); reti_pulse = 1'b0; reg_wr_en = 1'b0;
    chk("R7 RETI over write", reg_rd_data[0], 1);

    // R7: take together with RETI leaves gie cleared
    wr(8'h13);
    @(negedge clk); cyc_strobe = 1'b1; reti_pulse = 1'b1;
    @(negedge clk); cyc_strobe = 1'b0; reti_pulse = 1'b0;
    chk("R7 take with RETI", take_pulse, 1);
    chk("R7 gie after take+RETI", reg_rd_data[0], 0);

    // R9: hardware set vs take clear
    wr(8'h13);
    @(negedge clk); cyc_strobe = 1'b1; usb_reset_evt = 1'b1;
    @(negedge clk); cyc_strobe = 1'b0; usb_reset_evt = 1'b0;
    chk("R9 take", take_pulse, 1);
    chk("R9 vector", vector_addr, 8'h04);
    chk("R9 flag kept", reg_rd_data[4], 1);

    // R9: hardware set vs write of 0
    wr(8'h20);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = 8'h00; tmr0_ovf = 1'b1;
    @(negedge clk); reg_wr_en = 1'b0; tmr0_ovf = 1'b0;
    chk("R9 set beats write", reg_rd_data, 8'h20);
    wr(8'h00);
    chk("R1 write 0 clears", reg_rd_data, 8'h00);
    chk("R10 wake idle", wake_req, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule